// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block sits beside the operand fetch stage of a small 8-bit microcontroller core. It takes an operand specifier (the addressing mode and the operand field of an instruction) together with the bank-select bits and the current contents of the two pointer registers. From these it produces the physical internal-memory address to access. It also says whether that address lands in internal RAM or in the special function register (SFR) space and, for single-bit operands, which bit inside the byte is meant.

The main subtlety is that one 8-bit value can mean two different places. The upper half (80H–FFH) reaches the SFR space when it is written as a direct address, but it reaches upper internal RAM when it comes from a pointer register. Register operands, in turn, are relocated by the active bank. The result is captured on a clock edge that carries a request strobe and is presented, with its own valid flag, in the cycle that follows. The memory arrays, instruction decode and execution datapath lie outside this block.

Top module: `opnd_addr_resolver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_valid`, `res_addr`, `res_sfr` and `res_bit` are all zero.
- R2: Register mode (`req_mode` = 0): `res_addr` = `bank_sel`×8 + `req_opnd[2:0]`, `res_sfr` = 0.
- R3: Direct mode (`req_mode` = 1): `res_addr` = `req_opnd`, and `res_sfr` equals `req_opnd[7]`.
- R4: Indirect mode (`req_mode` = 2): `req_opnd[0]` picks `ptr_lo` (0) or `ptr_hi` (1). `res_addr` is that pointer value and `res_sfr` = 0, even for pointer values 80H–FFH.
- R5: Bit mode (`req_mode` = 3) with `req_opnd` below 80H: `res_addr` = 20H + `req_opnd[6:3]`, `res_sfr` = 0.
- R6: Bit mode with `req_opnd` at 80H or above: `res_addr` = {`req_opnd[7:3]`, 000}, `res_sfr` = 1.
- R7: `res_bit` equals `req_opnd[2:0]` in bit mode and is 0 in every other mode.
- R8: A request is captured on a rising edge where `req_valid` is 1. Its result and `res_valid` = 1 appear on the outputs after that edge. `res_valid` is 0 after an edge without a request.
- R9: On an edge without `req_valid`, `res_addr`, `res_sfr` and `res_bit` keep their values, whatever the other inputs do.
- R10: Fields a mode does not use have no effect: `req_opnd[7:3]` in register mode, `req_opnd[7:1]` in indirect mode, and `bank_sel` and the pointers in direct and bit modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | Addressing mode: 0 register, 1 direct, 2 indirect, 3 bit |
| req_opnd | input | 8 | Operand field: register number, pointer select, direct address or bit address |
| bank_sel | input | 2 | Active register bank |
| ptr_lo | input | 8 | Current contents of pointer register 0 of the active bank |
| ptr_hi | input | 8 | Current contents of pointer register 1 of the active bank |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_addr | output | 8 | Resolved internal address |
| res_sfr | output | 1 | 1 = SFR space, 0 = internal RAM |
| res_bit | output | 3 | Bit index inside the addressed byte (bit mode only) |

## Verification
Two things can happen in the same cycle. A new request is captured while the previous result is still on the outputs, and that request may also switch mode, so the RAM/SFR split and the bank relocation meet on one edge. The bench drives back-to-back strobes with random modes, banks and pointer values. Between them it inserts idle cycles in which every other input is scrambled. After each edge it compares the outputs with a reference function: a fresh expectation after a strobe, and the held one after an idle cycle.

// File: rtl/oar_pkg.sv
package oar_pkg;

    typedef enum logic [1:0] {
        MODE_REG = 2'd0,
        MODE_DIR = 2'd1,
        MODE_IND = 2'd2,
        MODE_BIT = 2'd3
    } opnd_mode_e;

endpackage

// File: rtl/oar_bank_map.sv
module oar_bank_map #(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 2,
    parameter int REG_IDX_W = 3
) (
    input  logic [BANK_W-1:0]    bank,
    input  logic [REG_IDX_W-1:0] reg_idx,
    output logic [ADDR_W-1:0]    ram_addr
);
    localparam int PAD_W = ADDR_W - BANK_W - REG_IDX_W;

    // bank * 2^REG_IDX_W + index is a plain concatenation
    generate
        if (PAD_W > 0) begin : g_pad
            assign ram_addr = {{PAD_W{1'b0}}, bank, reg_idx};
        end else begin : g_nopad
            assign ram_addr = {bank, reg_idx};
        end
    endgenerate
endmodule

// File: rtl/oar_bit_map.sv
module oar_bit_map #(
    parameter int              ADDR_W       = 8,
    parameter int              BIT_IDX_W    = 3,
    parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
    input  logic [ADDR_W-1:0]    bit_addr,
    output logic [ADDR_W-1:0]    byte_addr,
    output logic                 in_sfr,
    output logic [BIT_IDX_W-1:0] bit_idx
);
    localparam int BYTE_SEL_W = ADDR_W - 1 - BIT_IDX_W;
    localparam int PAD_W      = ADDR_W - BYTE_SEL_W;

    logic [BYTE_SEL_W-1:0] ram_byte_sel;
    logic [ADDR_W-1:0]     ram_byte;
    logic [ADDR_W-1:0]     sfr_byte;

    assign ram_byte_sel = bit_addr[ADDR_W-2:BIT_IDX_W];
    assign ram_byte     = BIT_RAM_BASE + {{PAD_W{1'b0}}, ram_byte_sel};
    assign sfr_byte     = {bit_addr[ADDR_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};

    assign in_sfr    = bit_addr[ADDR_W-1];
    assign byte_addr = in_sfr ? sfr_byte : ram_byte;
    assign bit_idx   = bit_addr[BIT_IDX_W-1:0];
endmodule

// File: rtl/opnd_addr_resolver.sv
module opnd_addr_resolver #(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 2,
    parameter int REG_IDX_W = 3,
    parameter int BIT_IDX_W = 3,
    parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_mode,
    input  logic [ADDR_W-1:0]    req_opnd,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [ADDR_W-1:0]    ptr_lo,
    input  logic [ADDR_W-1:0]    ptr_hi,
    output logic                 res_valid,
    output logic [ADDR_W-1:0]    res_addr,
    output logic                 res_sfr,
    output logic [BIT_IDX_W-1:0] res_bit
);
    import oar_pkg::*;

    typedef struct packed {
        logic                 valid;
        logic [ADDR_W-1:0]    addr;
        logic                 sfr;
        logic [BIT_IDX_W-1:0] bidx;
    } res_t;

    localparam res_t RES_RESET = '0;

    res_t res_d, res_q;

    logic [ADDR_W-1:0]    bank_addr;
    logic [ADDR_W-1:0]    bit_byte;
    logic                 bit_sfr;
    logic [BIT_IDX_W-1:0] bit_idx;
    opnd_mode_e           mode;

    assign mode = opnd_mode_e'(req_mode);

    oar_bank_map #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .REG_IDX_W (REG_IDX_W)
    ) u_bank_map (
        .bank     (bank_sel),
        .reg_idx  (req_opnd[REG_IDX_W-1:0]),
        .ram_addr (bank_addr)
    );

    oar_bit_map #(
        .ADDR_W       (ADDR_W),
        .BIT_IDX_W    (BIT_IDX_W),
        .BIT_RAM_BASE (BIT_RAM_BASE)
    ) u_bit_map (
        .bit_addr  (req_opnd),
        .byte_addr (bit_byte),
        .in_sfr    (bit_sfr),
        .bit_idx   (bit_idx)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.bidx = '0;
            res_d.sfr  = 1'b0;
            unique case (mode)
                MODE_REG: res_d.addr = bank_addr;
                MODE_DIR: begin
                    res_d.addr = req_opnd;
                    res_d.sfr  = req_opnd[ADDR_W-1];
                end
                MODE_IND: res_d.addr = req_opnd[0] ? ptr_hi : ptr_lo;
                MODE_BIT: begin
                    res_d.addr = bit_byte;
                    res_d.sfr  = bit_sfr;
                    res_d.bidx = bit_idx;
                end
                default: res_d.addr = req_opnd;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= RES_RESET;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_addr  = res_q.addr;
    assign res_sfr   = res_q.sfr;
    assign res_bit   = res_q.bidx;
endmodule

// File: rtl/oar_checker.sv
module oar_checker #(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 2,
    parameter int BIT_IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_mode,
    input logic [ADDR_W-1:0]    req_opnd,
    input logic [BANK_W-1:0]    bank_sel,
    input logic [ADDR_W-1:0]    ptr_lo,
    input logic [ADDR_W-1:0]    ptr_hi,
    input logic                 res_valid,
    input logic [ADDR_W-1:0]    res_addr,
    input logic                 res_sfr,
    input logic [BIT_IDX_W-1:0] res_bit
);
    assert_direct_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_mode == 2'd1) |->
            (res_addr == $past(req_opnd) && res_sfr == $past(req_opnd[ADDR_W-1])));

    assert_indirect_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_mode == 2'd2) |->
            (!res_sfr && res_addr == $past(req_opnd[0] ? ptr_hi : ptr_lo)));

    assert_bank_relocate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_mode == 2'd0) |->
            (!res_sfr && res_addr[BANK_W+2:3] == $past(bank_sel)
                      && res_addr[2:0] == $past(req_opnd[2:0])));

    assert_bit_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |->
            (res_bit == ($past(req_mode) == 2'd3 ? $past(req_opnd[BIT_IDX_W-1:0]) : '0)));

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(req_valid));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(res_addr) && $stable(res_sfr) && $stable(res_bit)));
endmodule

bind opnd_addr_resolver oar_checker #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .BIT_IDX_W (BIT_IDX_W)
) u_oar_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_opnd  (req_opnd),
    .bank_sel  (bank_sel),
    .ptr_lo    (ptr_lo),
    .ptr_hi    (ptr_hi),
    .res_valid (res_valid),
    .res_addr  (res_addr),
    .res_sfr   (res_sfr),
    .res_bit   (res_bit)
);

// File: tb/opnd_addr_resolver_test.sv
module opnd_addr_resolver_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [7:0] req_opnd = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic [7:0] ptr_lo = 8'h00;
    logic [7:0] ptr_hi = 8'h00;
    logic       res_valid;
    logic [7:0] res_addr;
    logic       res_sfr;
    logic [2:0] res_bit;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    opnd_addr_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_opnd(req_opnd), .bank_sel(bank_sel), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
        .res_valid(res_valid), .res_addr(res_addr), .res_sfr(res_sfr), .res_bit(res_bit)
    );

    // expected {addr, sfr, bit}
    function automatic logic [11:0] model(input logic [1:0] m, input logic [7:0] op,
                                          input logic [1:0] bk, input logic [7:0] p0,
                                          input logic [7:0] p1);
        logic [7:0] a;
        logic       s;
        logic [2:0] b;
        b = 3'd0;
        s = 1'b0;
        case (m)
            2'd0: a = 8'(bk) * 8'd8 + 8'(op[2:0]);
            2'd1: begin a = op; s = (op >= 8'h80); end
            2'd2: a = op[0] ? p1 : p0;
            default: begin
                b = op[2:0];
                if (op < 8'h80) a = 8'h20 + 8'(op[6:3]);
                else begin a = op & 8'hF8; s = 1'b1; end
            end
        endcase
        return {a, s, b};
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic [7:0] op);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return (op < 8'h80) ? "R5/R7" : "R6/R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual valid/addr/sfr/bit=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [11:0] last_exp = 12'h000;

    // drive at negedge, the posedge between captures, sample at next negedge
    task automatic strobe(input logic [1:0] m, input logic [7:0] op, input logic [1:0] bk,
                          input logic [7:0] p0, input logic [7:0] p1, input string tag);
        req_valid = 1'b1; req_mode = m; req_opnd = op; bank_sel = bk; ptr_lo = p0; ptr_hi = p1;
        last_exp = model(m, op, bk, p0, p1);
        @(negedge clk);
        check(tag, {res_valid, res_addr, res_sfr, res_bit}, {1'b1, last_exp});
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        req_mode = 2'($urandom); req_opnd = 8'($urandom); bank_sel = 2'($urandom);
        ptr_lo = 8'($urandom); ptr_hi = 8'($urandom);
        @(negedge clk);
        check(tag, {res_valid, res_addr, res_sfr, res_bit}, {1'b0, last_exp});
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        @(negedge clk);
        check("R1 in reset", {res_valid, res_addr, res_sfr, res_bit}, 13'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {res_valid, res_addr, res_sfr, res_bit}, 13'd0);

        // directed corners
        strobe(2'd0, 8'h07, 2'd3, 8'h00, 8'h00, "R2 bank3 r7");
        strobe(2'd0, 8'hF8, 2'd2, 8'h00, 8'h00, "R2/R10 upper bits ignored");
        strobe(2'd1, 8'h7F, 2'd1, 8'h00, 8'h00, "R3 top of RAM");
        strobe(2'd1, 8'h80, 2'd0, 8'h00, 8'h00, "R3 first SFR");
        strobe(2'd2, 8'h00, 2'd0, 8'hC5, 8'h33, "R4 ptr0 upper RAM");
        strobe(2'd2, 8'hFF, 2'd0, 8'h12, 8'hFF, "R4/R10 ptr1");
        strobe(2'd3, 8'h7F, 2'd0, 8'h00, 8'h00, "R5 last RAM bit");
        strobe(2'd3, 8'h00, 2'd3, 8'hAA, 8'hAA, "R5/R10 first RAM bit");
        strobe(2'd3, 8'h80, 2'd0, 8'h00, 8'h00, "R6 first SFR bit");
        strobe(2'd3, 8'hD5, 2'd1, 8'h00, 8'h00, "R6/R7 mid SFR bit");
        strobe(2'd1, 8'h45, 2'd3, 8'h99, 8'h66, "R7/R10 bit index zero");
        idle("R9 hold after direct");
        idle("R8 idle valid low");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic [7:0] op;
            m  = 2'($urandom);
            op = 8'($urandom);
            if ($urandom_range(3) == 0) idle("R9 random hold");
            else strobe(m, op, 2'($urandom), 8'($urandom), 8'($urandom), tag_of(m, op));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule